// File: doc/BRIEF.md
# Four-Lane Table-Driven CRC-32 Engine

The engine folds one whole 32-bit word per clock into a reflected CRC-32 remainder. On each accepted beat the incoming word is XORed with the current remainder. Each of the four bytes of that sum then addresses its own 256-entry constant table, and the next remainder is the XOR of the four table outputs. Each table cancels a different span of polynomial coefficients, so every table is different. All tables are computed at elaboration from the polynomial parameter, and no external memory is needed.

A frame is a run of valid beats. The beat with `in_start` high begins from the all-ones preset, and the beat with `in_last` high closes the frame. The complemented remainder appears on `crc_out` together with a one-cycle `crc_valid` pulse in the cycle after the closing beat. Callers supply whole words only. Byte lane 0 (`in_data[7:0]`) is the first transmitted byte, and every byte is taken least significant bit first.

Top module: `crc4_slice_engine`

## Requirements
- R1: After reset, `crc_valid` is 0 and `crc_out` is 32'h00000000, because the remainder holds the all-ones preset and the output is its complement.
- R2: The remainder follows the reflected polynomial 32'hEDB88320. Bits are taken in the order in_data[0], in_data[1], … in_data[31], so byte lane 0 is processed first and LSB first.
- R3: A valid beat with `in_start` high starts from the all-ones preset, whatever state the previous frame left behind.
- R4: A valid beat without `in_start` folds its word into the running remainder, one word per cycle, with no stall.
- R5: In the cycle after a valid beat with `in_last` high, `crc_valid` is 1 for exactly one cycle and `crc_out` equals the bitwise complement of the remainder.
- R6: While `in_valid` is 0, `in_start`, `in_last` and `in_data` are ignored: the remainder and `crc_out` stay unchanged and no `crc_valid` pulse is produced.
- R7: A single beat carrying both `in_start` and `in_last` forms a complete one-word frame.
- R8: A new frame may start in the cycle right after a closing beat. The earlier result is still presented correctly in that cycle.
- R9: The nine ASCII bytes "123456789" padded with three zero bytes into three words yield the same CRC as the bitwise model over those twelve bytes. The unpadded model value for "123456789" is 32'hCBF43926.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word beat present |
| in_start | input | 1 | Beat is the first of a frame (preset first) |
| in_last | input | 1 | Beat is the last of a frame |
| in_data | input | 32 | Data word, byte lane 0 transmitted first |
| crc_out | output | 32 | Complemented remainder |
| crc_valid | output | 1 | One-cycle pulse: crc_out holds a finished frame result |

## Verification
Frames of 1 to 64 random words are compared against a one-bit-per-step model. This separates a wrong table span or a swapped lane from a correct fold, because every lane value reaches every table. The padded "123456789" frame and an all-zero single word pin down the polynomial and the bit order. Idle cycles with `in_start`, `in_last` and junk data raised mid-frame show that the qualifiers are ignored. Back-to-back frames show that the preset overrides a stale remainder.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
   localparam int unsigned CRC_BITS  = 32;
   localparam int unsigned LUT_DEPTH = 256;

   // Remainder left by byte idx followed by extra_bytes zero bytes (reflected form).
   function automatic logic [31:0] lut_entry(input logic [31:0] poly,
                                             input int unsigned idx,
                                             input int unsigned extra_bytes);
      logic [31:0] r;
      r = 32'(idx);
      for (int n = 0; n < 8 * (extra_bytes + 1); n++)
         r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
      return r;
   endfunction
endpackage

// File: rtl/crc4_lane_lut.sv
module crc4_lane_lut #(
   parameter logic [31:0] POLY       = 32'hEDB88320,
   parameter int unsigned ZERO_BYTES = 0
) (
   input  logic [7:0]  idx,
   output logic [31:0] value
);
   logic [31:0] table_q [crc4_pkg::LUT_DEPTH];

   for (genvar k = 0; k < crc4_pkg::LUT_DEPTH; k++) begin : g_entry
      assign table_q[k] = crc4_pkg::lut_entry(POLY, k, ZERO_BYTES);
   end

   assign value = table_q[idx];
endmodule

// File: rtl/crc4_fold.sv
module crc4_fold #(
   parameter logic [31:0] POLY  = 32'hEDB88320,
   parameter int unsigned LANES = 4
) (
   input  logic [8*LANES-1:0] rem_in,
   input  logic [8*LANES-1:0] word,
   output logic [8*LANES-1:0] rem_next
);
   localparam int unsigned W = 8 * LANES;

   logic [W-1:0] mixed;
   logic [W-1:0] part [LANES];

   assign mixed = rem_in ^ word;

   // Earlier lanes see more trailing zero bytes, so they use longer-span tables.
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      crc4_lane_lut #(
         .POLY      (POLY),
         .ZERO_BYTES(LANES - 1 - b)
      ) u_lut (
         .idx  (mixed[8*b +: 8]),
         .value(part[b])
      );
   end

   always_comb begin
      rem_next = '0;
      for (int b = 0; b < LANES; b++)
         rem_next = rem_next ^ part[b];
   end
endmodule

// File: rtl/crc4_slice_engine.sv
module crc4_slice_engine #(
   parameter int unsigned CRC_W  = 32,
   parameter logic [31:0] POLY   = 32'hEDB88320,
   parameter logic [31:0] INIT   = 32'hFFFFFFFF,
   parameter logic [31:0] XOROUT = 32'hFFFFFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_start,
   input  logic        in_last,
   input  logic [31:0] in_data,
   output logic [31:0] crc_out,
   output logic        crc_valid
);
   localparam int unsigned LANES = CRC_W / 8;

   if (CRC_W != crc4_pkg::CRC_BITS) begin : g_bad_width
      $error("crc4_slice_engine: CRC_W must be 32");
   end
   if (POLY[31] == 1'b0) begin : g_bad_poly
      $error("crc4_slice_engine: reflected POLY must have bit 31 set");
   end

   logic [31:0] rem_q;
   logic [31:0] rem_base;
   logic [31:0] rem_next;
   logic        done_q;

   assign rem_base = in_start ? INIT : rem_q;

   crc4_fold #(
      .POLY (POLY),
      .LANES(LANES)
   ) u_fold (
      .rem_in  (rem_base),
      .word    (in_data),
      .rem_next(rem_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= INIT;
         done_q <= 1'b0;
      end else begin
         done_q <= in_valid & in_last;
         if (in_valid)
            rem_q <= rem_next;
      end
   end

   assign crc_out   = rem_q ^ XOROUT;
   assign crc_valid = done_q;
endmodule

// File: rtl/crc4_slice_engine_chk.sv
module crc4_slice_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_last,
   input logic [31:0] crc_out,
   input logic        crc_valid
);
   // R5
   pulse_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> crc_valid);

   // R6
   no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_last) |=> !crc_valid);

   // R6
   idle_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(crc_out));

   // R5
   result_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_valid |-> !$isunknown(crc_out));
endmodule

bind crc4_slice_engine crc4_slice_engine_chk i_chk (.*);

// File: tb/test_crc4_slice_engine.sv
`timescale 1ns/1ps
module test_crc4_slice_engine;
   localparam logic [31:0] POLY = 32'hEDB88320;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_start = 1'b0;
   logic        in_last = 1'b0;
   logic [31:0] in_data = '0;
   logic [31:0] crc_out;
   logic        crc_valid;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] frame [64];

   always #2 clk = ~clk;

   crc4_slice_engine i_crc4_slice_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_last(in_last), .in_data(in_data), .crc_out(crc_out), .crc_valid(crc_valid)
   );

   function automatic logic [31:0] ref_word(input logic [31:0] c, input logic [31:0] w);
      for (int i = 0; i < 32; i++) begin
         c = c ^ {31'd0, w[i]};
         c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
      end
      return c;
   endfunction

   function automatic logic [31:0] ref_frame(input int len);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) c = ref_word(c, frame[i]);
      return ~c;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Drive frame[0..len-1]; idle cycles with junk qualifiers every gap_every beats.
   task automatic send_frame(input int len, input int gap_every);
      for (int i = 0; i < len; i++) begin
         if (gap_every > 0 && i > 0 && (i % gap_every) == 0) begin
            logic [31:0] held;
            @(negedge clk);
            held = crc_out;
            in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1; in_data = $urandom;
            @(negedge clk);
            check("R6 idle no pulse", {31'd0, crc_valid}, 32'd0);
            check("R6 idle hold", crc_out, held);
         end else begin
            @(negedge clk);
         end
         in_valid = 1'b1; in_start = (i == 0); in_last = (i == len - 1); in_data = frame[i];
      end
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_data = $urandom;
   endtask

   task automatic expect_result(input string req, input logic [31:0] exp);
      logic [31:0] held;
      check({req, " pulse"}, {31'd0, crc_valid}, 32'd1);
      check(req, crc_out, exp);
      held = crc_out;
      @(negedge clk);
      check("R5 one-cycle pulse", {31'd0, crc_valid}, 32'd0);
      check("R6 result held", crc_out, held);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid low", {31'd0, crc_valid}, 32'd0);
      check("R1 out zero", crc_out, 32'h00000000);
   endtask

   task automatic t_known();
      logic [31:0] c = 32'hFFFFFFFF;
      byte unsigned s [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      for (int i = 0; i < 9; i++) begin
         c = c ^ {24'd0, s[i]};
         for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
      end
      check("R9 model check value", ~c, 32'hCBF43926);
      frame[0] = 32'h34333231; frame[1] = 32'h38373635; frame[2] = 32'h00000039;
      send_frame(3, 0);
      expect_result("R9 R2 padded digits", ref_frame(3));
   endtask

   task automatic t_single_zero();
      frame[0] = 32'h0;
      send_frame(1, 0);
      expect_result("R7 R2 single zero word", 32'h2144DF1C);
   endtask

   task automatic t_back_to_back();
      logic [31:0] exp_a, exp_b;
      frame[0] = 32'hDEADBEEF; frame[1] = 32'h01234567;
      exp_a = ref_frame(2);
      frame[2] = 32'hCAFEF00D;
      @(negedge clk);
      in_valid = 1; in_start = 1; in_last = 0; in_data = frame[0];
      @(negedge clk);
      in_start = 0; in_last = 1; in_data = frame[1];
      @(negedge clk);
      check("R8 first result pulse", {31'd0, crc_valid}, 32'd1);
      check("R8 first result", crc_out, exp_a);
      in_start = 1; in_last = 1; in_data = frame[2];
      @(negedge clk);
      in_valid = 0; in_start = 0; in_last = 0;
      frame[0] = 32'hCAFEF00D;
      exp_b = ref_frame(1);
      expect_result("R3 R8 restart after frame", exp_b);
   endtask

   task automatic t_random();
      for (int f = 0; f < 40; f++) begin
         int len;
         len = (f == 0) ? 64 : 1 + ($urandom % 64);
         for (int i = 0; i < len; i++) frame[i] = $urandom;
         send_frame(len, (f % 3 == 0) ? 5 : 0);
         expect_result("R4 R2 random frame", ref_frame(len));
      end
   endtask

   initial begin
      #(4 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_single_zero();
      t_known();
      t_back_to_back();
      t_random();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule